// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block gathers the interrupt sources of a serial port into a single interrupt request and a 4-bit identification value that software reads to learn why it was interrupted. Five sources are considered: receiver line errors, received data reaching a programmable fill threshold, a character timeout, the transmit holding register becoming empty, and changes on the modem control inputs. Only the most urgent enabled source is reported at any time.

Receiver errors, modem-input changes and transmit-empty transitions are event sources. Each is held in a sticky flag until software performs the access that serves it. Data-available and timeout are level conditions. They follow the receive FIFO fill level and the timeout timer directly. A 4-bit enable vector gates which sources may be reported. A flag whose source is disabled is still kept, and it is reported once its enable is set. The identification value and the interrupt request are both registered.

Top module: `uart_irq_ident`

## Requirements
- R1: While and after reset with no source active, `iir` reads 4'b0001 and `irq` is 0.
- R2: Sources whose enable bit is 0 are not reported. Enable bit 0 gates data-available and timeout, bit 1 gates transmit-empty, bit 2 gates line errors and bit 3 gates modem changes. With no enabled source active, `iir` is 4'b0001 and `irq` is 0.
- R3: A pulse on any bit of `rx_err_evt` sets a sticky line-error flag, reported as code 3'b011 (`iir`=4'b0110). A pulse on `lsr_rd` clears the flag. If a new error arrives in the same cycle as `lsr_rd`, the flag stays set.
- R4: Data-available is active while `rx_level` >= threshold and is reported as code 3'b010 (`iir`=4'b0100). The threshold is chosen by `trig_sel`: 0 selects 1, 1 selects DEPTH/4, 2 selects DEPTH/2 and 3 selects DEPTH-2.
- R5: While `rx_timeout` is high, the timeout condition is reported as code 3'b110 (`iir`=4'b1100). It is enabled by the same bit as data-available.
- R6: A 0-to-1 transition of `thr_empty` sets a sticky transmit-empty flag, reported as code 3'b001 (`iir`=4'b0010). The flag clears on `thr_wr`, or on `iir_rd` while `iir` reads 4'b0010. If `thr_wr` arrives in the same cycle as a new transition, the flag ends up clear.
- R7: `iir_rd` while another source is reported leaves the transmit-empty flag set.
- R8: A pulse on any bit of `msr_delta` sets a sticky modem flag, reported as code 3'b000 with pending bit 0 (`iir`=4'b0000). A pulse on `msr_rd` clears the flag.
- R9: When several enabled sources are active, the reported source follows this order, highest first: line error, data-available, timeout, transmit-empty, modem.
- R10: `irq` is the inverse of `iir[0]`, and both are registered. A level condition shows on `iir` one clock edge after it is presented. A sticky event shows two edges after its strobe. An input change never affects `iir` before the next edge.
- R11: Sticky flags are kept while their source is disabled, and they are reported as soon as their enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 4 | Source enable vector |
| rx_err_evt | input | ERR_W | Receiver error event pulses |
| rx_level | input | CNT_W | Receive FIFO fill level |
| trig_sel | input | 2 | Data-available threshold select |
| rx_timeout | input | 1 | Character timeout condition |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_delta | input | MS_W | Modem input change pulses |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| iir | output | 4 | Identification value: code in [3:1], active-low pending flag in [0] |
| irq | output | 1 | Interrupt request |

## Verification
The main instance uses DEPTH=16, which gives thresholds of 1, 4, 8 and 14. For each threshold the bench checks the level one below it and the level exactly at it. A second instance uses DEPTH=8, whose thresholds are 1, 2, 4 and 6. This shows that the threshold arithmetic scales with the parameter and is not tied to one FIFO size. Both instances keep ERR_W and MS_W at 4, so a single error bit and a single modem-change bit are enough to show that any bit sets the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_TXEMPTY = 3'b001,
    ID_RXDATA  = 3'b010,
    ID_LINE    = 3'b011,
    ID_TIMEOUT = 3'b110
  } irq_id_e;

  localparam int EN_RXDATA  = 0;
  localparam int EN_TXEMPTY = 1;
  localparam int EN_LINE    = 2;
  localparam int EN_MODEM   = 3;
  localparam int EN_W       = 4;
  localparam int IIR_W      = 4;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter int N        = 1,
  parameter bit CLR_WINS = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic         q
);
  logic set_any;
  assign set_any = |set_vec;

  generate
    if (CLR_WINS) begin : g_clr_wins
      always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (clr)     q <= 1'b0;
        else if (set_any) q <= 1'b1;
      end
      AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !q); // R6
    end else begin : g_set_wins
      always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (set_any) q <= 1'b1;
        else if (clr)     q <= 1'b0;
      end
      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(set_any) |-> q); // R3
    end
  endgenerate

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(set_any) && !$past(clr) && !$past(rst)) |-> $stable(q)); // R11
endmodule

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  input  logic [1:0]       sel,
  output logic             hit
);
  localparam logic [CNT_W-1:0] TH0 = CNT_W'(1);
  localparam logic [CNT_W-1:0] TH1 = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] TH2 = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TH3 = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0] thresh;
  always_comb begin
    case (sel)
      2'd0:    thresh = TH0;
      2'd1:    thresh = TH1;
      2'd2:    thresh = TH2;
      default: thresh = TH3;
    endcase
  end

  assign hit = (level >= thresh);

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !hit); // R4
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [EN_W-1:0] ier,
  input  logic            line_p,
  input  logic            rxdata,
  input  logic            timeout,
  input  logic            txempty_p,
  input  logic            modem_p,
  output logic [IIR_W-1:0] iir_q,
  output logic            irq_q
);
  irq_id_e code;
  logic    any;
  logic    line_en, rx_en, to_en, tx_en, ms_en;

  assign line_en = line_p    & ier[EN_LINE];
  assign rx_en   = rxdata    & ier[EN_RXDATA];
  assign to_en   = timeout   & ier[EN_RXDATA];
  assign tx_en   = txempty_p & ier[EN_TXEMPTY];
  assign ms_en   = modem_p   & ier[EN_MODEM];

  always_comb begin
    any  = 1'b1;
    code = ID_MODEM;
    if (line_en)      code = ID_LINE;
    else if (rx_en)   code = ID_RXDATA;
    else if (to_en)   code = ID_TIMEOUT;
    else if (tx_en)   code = ID_TXEMPTY;
    else if (ms_en)   code = ID_MODEM;
    else              any  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= 4'b0001;
      irq_q <= 1'b0;
    end else begin
      iir_q <= {code, ~any};
      irq_q <= any;
    end
  end

  AST_IDLE_READS_ONE: assert property (@(posedge clk) disable iff (rst)
    iir_q[0] |-> (iir_q[3:1] == 3'b000)); // R2
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (!iir_q[0] && !$past(rst)) |-> $past(|ier)); // R2
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(line_en)) |-> (iir_q == 4'b0110)); // R9
  AST_MODEM_LAST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ms_en) && !$past(line_en | rx_en | to_en | tx_en))
      |-> (iir_q == 4'b0000)); // R8
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ERR_W = 4,
  parameter int MS_W  = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier,
  input  logic [ERR_W-1:0] rx_err_evt,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [1:0]       trig_sel,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic [MS_W-1:0]  msr_delta,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  output logic [3:0]       iir,
  output logic             irq
);
  logic line_p, modem_p, txempty_p, rxdata;
  logic thr_empty_d, tx_rise, tx_clr;

  always_ff @(posedge clk) begin
    if (rst) thr_empty_d <= 1'b1;
    else     thr_empty_d <= thr_empty;
  end

  assign tx_rise = thr_empty & ~thr_empty_d;
  assign tx_clr  = thr_wr | (iir_rd & (iir == {ID_TXEMPTY, 1'b0}));

  uart_irq_flag #(.N(ERR_W), .CLR_WINS(1'b0)) u_line (
    .clk(clk), .rst(rst), .set_vec(rx_err_evt), .clr(lsr_rd), .q(line_p));

  uart_irq_flag #(.N(MS_W), .CLR_WINS(1'b0)) u_modem (
    .clk(clk), .rst(rst), .set_vec(msr_delta), .clr(msr_rd), .q(modem_p));

  uart_irq_flag #(.N(1), .CLR_WINS(1'b1)) u_txempty (
    .clk(clk), .rst(rst), .set_vec(tx_rise), .clr(tx_clr), .q(txempty_p));

  uart_irq_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .clk(clk), .rst(rst), .level(rx_level), .sel(trig_sel), .hit(rxdata));

  uart_irq_encode u_enc (
    .clk(clk), .rst(rst), .ier(ier),
    .line_p(line_p), .rxdata(rxdata), .timeout(rx_timeout),
    .txempty_p(txempty_p), .modem_p(modem_p),
    .iir_q(iir), .irq_q(irq));

  AST_IRQ_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq == !iir[0]); // R10
  AST_IIR_READ_CLEARS_TX: assert property (@(posedge clk) disable iff (rst)
    ($past(iir_rd) && ($past(iir) == 4'b0010)) |-> !txempty_p); // R6
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] ier;
  logic [3:0] rx_err_evt;
  logic [4:0] rx_level;
  logic [3:0] rx_level_s;
  logic [1:0] trig_sel;
  logic       rx_timeout, thr_empty, thr_wr, iir_rd, lsr_rd, msr_rd;
  logic [3:0] msr_delta;
  logic [3:0] iir, iir_s;
  logic       irq, irq_s;
  int         n_checks = 0;
  int         n_fail   = 0;

  always #2 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst(rst), .ier(ier), .rx_err_evt(rx_err_evt), .rx_level(rx_level),
    .trig_sel(trig_sel), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
    .thr_wr(thr_wr), .msr_delta(msr_delta), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .msr_rd(msr_rd), .iir(iir), .irq(irq));

  uart_irq_ident #(.DEPTH(8)) u_small (
    .clk(clk), .rst(rst), .ier(ier), .rx_err_evt(4'b0), .rx_level(rx_level_s),
    .trig_sel(trig_sel), .rx_timeout(1'b0), .thr_empty(1'b0),
    .thr_wr(1'b0), .msr_delta(4'b0), .iir_rd(1'b0), .lsr_rd(1'b0),
    .msr_rd(1'b0), .iir(iir_s), .irq(irq_s));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: iir actual=%b expected=%b", req, act, exp);
    end
    n_checks++;
    if (irq !== ~exp[0]) begin
      n_fail++;
      $display("FAIL %s: irq actual=%b expected=%b", req, irq, ~exp[0]);
    end
  endtask

  task automatic pulse_err();
    rx_err_evt = 4'b0010; step(); rx_err_evt = '0;
  endtask

  task automatic pulse_msr();
    msr_delta = 4'b0100; step(); msr_delta = '0;
  endtask

  task automatic tx_rise();
    thr_empty = 1'b0; step(); thr_empty = 1'b1; step();
  endtask

  task automatic t_reset();
    rst = 1'b1; ier = '0; rx_err_evt = '0; rx_level = '0; rx_level_s = '0;
    trig_sel = '0; rx_timeout = 0; thr_empty = 0; thr_wr = 0; msr_delta = '0;
    iir_rd = 0; lsr_rd = 0; msr_rd = 0;
    repeat (5) step();
    check("R1 during reset", iir, 4'b0001);
    rst = 1'b0; step(); step();
    check("R1 after reset", iir, 4'b0001);
  endtask

  task automatic t_disabled_hold();
    ier = '0; rx_level = 5'd16; rx_timeout = 1;
    pulse_err(); pulse_msr(); tx_rise(); step();
    check("R2 disabled sources", iir, 4'b0001);
    rx_level = '0; rx_timeout = 0;
    ier = 4'b1000; step();
    check("R11 modem kept", iir, 4'b0000);
    ier = 4'b0010; step();
    check("R11 txempty kept", iir, 4'b0010);
    ier = 4'b0100; step();
    check("R11 line kept", iir, 4'b0110);
    lsr_rd = 1; msr_rd = 1; thr_wr = 1; step();
    lsr_rd = 0; msr_rd = 0; thr_wr = 0; ier = 4'b1111; step();
    check("R2 all cleared", iir, 4'b0001);
  endtask

  task automatic t_line();
    ier = 4'b0100;
    pulse_err(); step();
    check("R3 line error", iir, 4'b0110);
    lsr_rd = 1; step(); lsr_rd = 0; step();
    check("R3 lsr read clears", iir, 4'b0001);
    rx_err_evt = 4'b1000; lsr_rd = 1; step();
    rx_err_evt = '0; lsr_rd = 0; step();
    check("R3 new error beats read", iir, 4'b0110);
    lsr_rd = 1; step(); lsr_rd = 0; step();
    check("R3 cleared again", iir, 4'b0001);
  endtask

  task automatic t_rxdata();
    logic [4:0] th [4] = '{5'd1, 5'd4, 5'd8, 5'd14};
    ier = 4'b0001;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      rx_level = th[s] - 5'd1; step();
      check($sformatf("R4 below threshold sel=%0d", s), iir, 4'b0001);
      rx_level = th[s];
      check("R10 no change before edge", iir, 4'b0001);
      step();
      check($sformatf("R4 at threshold sel=%0d", s), iir, 4'b0100);
    end
    rx_level = '0; trig_sel = '0; step();
    check("R4 drained", iir, 4'b0001);
  endtask

  task automatic t_timeout();
    ier = 4'b0001; rx_timeout = 1; step();
    check("R5 timeout", iir, 4'b1100);
    ier = 4'b1110; step();
    check("R5 gated by bit 0", iir, 4'b0001);
    rx_timeout = 0; ier = 4'b0001; step();
    check("R5 timeout gone", iir, 4'b0001);
  endtask

  task automatic t_txempty();
    ier = 4'b0010;
    tx_rise(); step();
    check("R6 tx empty", iir, 4'b0010);
    iir_rd = 1; step(); iir_rd = 0; step();
    check("R6 iir read clears", iir, 4'b0001);
    tx_rise(); step();
    check("R6 tx empty again", iir, 4'b0010);
    thr_wr = 1; step(); thr_wr = 0; step();
    check("R6 write clears", iir, 4'b0001);
    thr_empty = 0; step(); thr_empty = 1; thr_wr = 1; step();
    thr_wr = 0; step();
    check("R6 write beats rise", iir, 4'b0001);
    ier = 4'b0011; tx_rise(); rx_level = 5'd1; step();
    check("R7 rxdata above tx", iir, 4'b0100);
    iir_rd = 1; step(); iir_rd = 0; rx_level = '0; step(); step();
    check("R7 tx survives other read", iir, 4'b0010);
    thr_wr = 1; step(); thr_wr = 0; step();
  endtask

  task automatic t_modem();
    ier = 4'b1000;
    pulse_msr(); step();
    check("R8 modem", iir, 4'b0000);
    msr_rd = 1; step(); msr_rd = 0; step();
    check("R8 msr read clears", iir, 4'b0001);
  endtask

  task automatic t_priority();
    ier = 4'b1111;
    rx_err_evt = 4'b0001; msr_delta = 4'b0001; thr_empty = 0; step();
    rx_err_evt = '0; msr_delta = '0; thr_empty = 1; rx_level = 5'd1; rx_timeout = 1; step(); step();
    check("R9 line first", iir, 4'b0110);
    lsr_rd = 1; step(); lsr_rd = 0; step();
    check("R9 rxdata second", iir, 4'b0100);
    rx_level = '0; step();
    check("R9 timeout third", iir, 4'b1100);
    rx_timeout = 0; step();
    check("R9 tx fourth", iir, 4'b0010);
    thr_wr = 1; step(); thr_wr = 0; step();
    check("R9 modem last", iir, 4'b0000);
    msr_rd = 1; step(); msr_rd = 0; step();
    check("R9 all served", iir, 4'b0001);
  endtask

  task automatic t_small();
    ier = 4'b0001;
    trig_sel = 2'd3; rx_level_s = 4'd5; step();
    n_checks++;
    if (iir_s !== 4'b0001) begin n_fail++; $display("FAIL R4 depth8 level5 sel3: actual=%b expected=0001", iir_s); end
    rx_level_s = 4'd6; step();
    n_checks++;
    if (iir_s !== 4'b0100) begin n_fail++; $display("FAIL R4 depth8 level6 sel3: actual=%b expected=0100", iir_s); end
    trig_sel = 2'd1; rx_level_s = 4'd1; step();
    n_checks++;
    if (iir_s !== 4'b0001) begin n_fail++; $display("FAIL R4 depth8 level1 sel1: actual=%b expected=0001", iir_s); end
    rx_level_s = 4'd2; step();
    n_checks++;
    if (iir_s !== 4'b0100 || irq_s !== 1'b1) begin n_fail++; $display("FAIL R4 depth8 level2 sel1: actual=%b/%b expected=0100/1", iir_s, irq_s); end
    rx_level_s = '0; trig_sel = '0;
  endtask

  initial begin
    t_reset();
    t_disabled_hold();
    t_line();
    t_rxdata();
    t_timeout();
    t_txempty();
    t_modem();
    t_priority();
    t_small();
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule